// File: doc/BRIEF.md
# Sync-Triggered Sample Pulse Generator

This block produces the timing strobes for a video sync measurement front end. It runs on a clock at the colour subcarrier rate. A one-cycle sync trigger arms a 9-bit counter. The counter then runs once from zero up to a terminal count, returns to idle and waits for the next trigger.

While the counter runs, three fixed count windows are decoded into strobes:
- an active-high gate around the leading sync edge;
- an active-low sync-tip sample;
- an active-low backporch sample.

An active-low vertical lockout input suppresses the two sample strobes during the vertical interval. The edge gate is not affected by the lockout. A busy flag shows when a run is in progress. All strobes are registered, so each follows its count window by one clock.

The sequencer has two states:
- `SEQ_IDLE`: the count is held at zero.
- `SEQ_RUN`: the count advances once per clock.

It has three transitions:
- START: `SEQ_IDLE` to `SEQ_RUN` when a trigger is sampled.
- WRAP: `SEQ_RUN` to `SEQ_IDLE` on the clock that sees the terminal count.
- RESET: any state to `SEQ_IDLE` when `rst` is high.

Top module: `sync_strobe_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs after that edge are `edge_gate`=0, `tip_samp_n`=1, `bp_samp_n`=1 and `busy`=0, and the count returns to zero.
- R2: Without a trigger the block stays in SEQ_IDLE: `busy` stays 0 and all strobes stay inactive, whatever the lockout does.
- R3: A `sync_trig` high at an edge in SEQ_IDLE makes `busy` 1 after that edge with count 0. The count then rises by one at each later edge.
- R4: `edge_gate` is 1 in exactly the cycles that follow the edges at which the count was GATE_START .. GATE_START+STROBE_LEN-1 (defaults 0..10, 11 cycles), and 0 at all other times.
- R5: `tip_samp_n` is 0 in exactly the cycles that follow the edges at which the count was TIP_START .. TIP_START+STROBE_LEN-1 (defaults 14..24) and `vlock_n` was 1. It is 1 at all other times.
- R6: `bp_samp_n` is 0 in exactly the cycles that follow the edges at which the count was BP_START .. BP_START+STROBE_LEN-1 (defaults 30..40) and `vlock_n` was 1. It is 1 at all other times.
- R7: `vlock_n`=0 at an edge forces both sample strobes to 1 after that edge and leaves `edge_gate` unchanged.
- R8: At the edge where the count equals TERM_CNT (default 511), the block returns to SEQ_IDLE. `busy` is therefore 1 for exactly TERM_CNT+1 cycles per run.
- R9: `sync_trig` sampled during SEQ_RUN, including at the terminal edge, neither restarts nor extends the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Subcarrier-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_trig | input | 1 | One-cycle sync trigger that arms a run |
| vlock_n | input | 1 | Vertical lockout, active low |
| edge_gate | output | 1 | Gate around the leading sync edge, active high |
| tip_samp_n | output | 1 | Sync-tip sample strobe, active low |
| bp_samp_n | output | 1 | Backporch sample strobe, active low |
| busy | output | 1 | High while a run is in progress |

## Verification
The assertions assume the parameter set keeps every window clear of the terminal count, so a strobe can only be active while `busy` is high. They also assume that `rst` is high at the first clock edge. The bench drives reset from time zero and uses only the default parameters. It also drives the trigger steadily high for long stretches, asserts it in the middle of a run and at the terminal edge, and pulses reset in the middle of a run, all of which the assertions must tolerate. No input pattern is excluded.

// File: rtl/strobe_pkg.sv
package strobe_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    localparam int NUM_STROBES = 3;
    localparam int IDX_GATE    = 0;
    localparam int IDX_TIP     = 1;
    localparam int IDX_BP      = 2;

endpackage

// File: rtl/strobe_seq_ctrl.sv
module strobe_seq_ctrl
    import strobe_pkg::*;
#(
    parameter int CNT_W    = 9,
    parameter int TERM_CNT = 511
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_i,
    output seq_state_e       state_o,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] TERM_V = CNT_W'(TERM_CNT);

    seq_state_e       state_q;
    seq_state_e       state_d;
    logic [CNT_W-1:0] count_q;
    logic             at_term;

    assign at_term = (count_q == TERM_V);

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (trig_i)  state_d = SEQ_RUN;   // START
            SEQ_RUN:  if (at_term) state_d = SEQ_IDLE;  // WRAP
            default:  state_d = SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;                        // RESET
        end else begin
            state_q <= state_d;
        end
    end

    // count register, driven by the current state
    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: count_q <= '0;
                SEQ_RUN:  count_q <= at_term ? '0 : count_q + 1'b1;
                default:  count_q <= '0;
            endcase
        end
    end

    assign state_o = state_q;
    assign count_o = count_q;

endmodule

// File: rtl/strobe_window_dec.sv
module strobe_window_dec #(
    parameter int CNT_W = 9,
    parameter int START = 0,
    parameter int LEN   = 11
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic             run_i,
    output logic             hit_o
);

    localparam logic [CNT_W:0] START_V = (CNT_W+1)'(START);
    localparam logic [CNT_W:0] LEN_V   = (CNT_W+1)'(LEN);

    logic [CNT_W:0] offset;

    // a count below START wraps to a value far above LEN
    assign offset = {1'b0, count_i} - START_V;
    assign hit_o  = run_i && (offset < LEN_V);

endmodule

// File: rtl/strobe_out_reg.sv
module strobe_out_reg #(
    parameter bit ACTIVE_LOW = 1'b0,
    parameter bit MASKABLE   = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic hit_i,
    input  logic lock_n_i,
    output logic strobe_o
);

    logic active;

    assign active = hit_i && (!MASKABLE || lock_n_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_o <= ACTIVE_LOW;
        end else begin
            strobe_o <= active ^ ACTIVE_LOW;
        end
    end

endmodule

// File: rtl/sync_strobe_gen.sv
module sync_strobe_gen
    import strobe_pkg::*;
#(
    parameter int CNT_W      = 9,
    parameter int TERM_CNT   = 511,
    parameter int STROBE_LEN = 11,
    parameter int GATE_START = 0,
    parameter int TIP_START  = 14,
    parameter int BP_START   = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_trig,
    input  logic vlock_n,
    output logic edge_gate,
    output logic tip_samp_n,
    output logic bp_samp_n,
    output logic busy
);

    localparam int  START_TAB [NUM_STROBES] = '{GATE_START, TIP_START, BP_START};
    localparam bit  LOW_TAB   [NUM_STROBES] = '{1'b0, 1'b1, 1'b1};
    localparam bit  MASK_TAB  [NUM_STROBES] = '{1'b0, 1'b1, 1'b1};

    seq_state_e             state;
    logic [CNT_W-1:0]       count;
    logic                   run;
    logic [NUM_STROBES-1:0] hit;
    logic [NUM_STROBES-1:0] strobe;

    strobe_seq_ctrl #(
        .CNT_W    (CNT_W),
        .TERM_CNT (TERM_CNT)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .trig_i  (sync_trig),
        .state_o (state),
        .count_o (count)
    );

    assign run = (state == SEQ_RUN);

    for (genvar i = 0; i < NUM_STROBES; i++) begin : g_strobe
        strobe_window_dec #(
            .CNT_W (CNT_W),
            .START (START_TAB[i]),
            .LEN   (STROBE_LEN)
        ) u_dec (
            .count_i (count),
            .run_i   (run),
            .hit_o   (hit[i])
        );

        strobe_out_reg #(
            .ACTIVE_LOW (LOW_TAB[i]),
            .MASKABLE   (MASK_TAB[i])
        ) u_reg (
            .clk      (clk),
            .rst      (rst),
            .hit_i    (hit[i]),
            .lock_n_i (vlock_n),
            .strobe_o (strobe[i])
        );
    end

    assign edge_gate  = strobe[IDX_GATE];
    assign tip_samp_n = strobe[IDX_TIP];
    assign bp_samp_n  = strobe[IDX_BP];
    assign busy       = run;

endmodule

// File: rtl/sync_strobe_gen_chk.sv
module sync_strobe_gen_chk #(
    parameter int CNT_W    = 9,
    parameter int TERM_CNT = 511
) (
    input logic clk,
    input logic rst,
    input logic sync_trig,
    input logic vlock_n,
    input logic edge_gate,
    input logic tip_samp_n,
    input logic bp_samp_n,
    input logic busy
);

    localparam logic [CNT_W:0] TERM_V = (CNT_W+1)'(TERM_CNT);

    // cycles of the current run seen so far
    logic [CNT_W:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            run_len <= '0;
        end else begin
            run_len <= run_len + 1'b1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!edge_gate && tip_samp_n && bp_samp_n && !busy)); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!busy && !sync_trig) |=> (!edge_gate && tip_samp_n && bp_samp_n && !busy)); // R2

    AST_TRIG_START: assert property (@(posedge clk) disable iff (rst)
        (!busy && sync_trig) |=> busy); // R3

    AST_GATE_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        $rose(edge_gate) |-> $past(busy)); // R4

    AST_TIP_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        !tip_samp_n |-> $past(busy)); // R5

    AST_BP_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        !bp_samp_n |-> $past(busy)); // R6

    AST_LOCK_MASK: assert property (@(posedge clk) disable iff (rst)
        !vlock_n |=> (tip_samp_n && bp_samp_n)); // R7

    AST_TERM_STOP: assert property (@(posedge clk) disable iff (rst)
        (busy && run_len == TERM_V) |=> !busy); // R8

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (busy && run_len != TERM_V) |=> (busy && run_len == $past(run_len) + 1'b1)); // R9

endmodule

bind sync_strobe_gen sync_strobe_gen_chk #(
    .CNT_W    (CNT_W),
    .TERM_CNT (TERM_CNT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sync_trig  (sync_trig),
    .vlock_n    (vlock_n),
    .edge_gate  (edge_gate),
    .tip_samp_n (tip_samp_n),
    .bp_samp_n  (bp_samp_n),
    .busy       (busy)
);

// File: tb/sync_strobe_gen_bench.sv
module sync_strobe_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TERM       = 511;
    localparam int SLEN       = 11;
    localparam int G0         = 0;
    localparam int T0         = 14;
    localparam int B0         = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_trig = 1'b0;
    logic vlock_n = 1'b1;
    logic edge_gate, tip_samp_n, bp_samp_n, busy;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // bench-side view of the run, built from the requirements
    bit m_run = 1'b0;
    int m_cnt = 0;

    // scoreboard: expected {gate, tip_n, bp_n, busy} plus requirement tags
    logic [3:0] exp_q [$];
    string      tg_q  [$];
    string      tt_q  [$];
    string      tb_q  [$];
    string      tz_q  [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_strobe_gen u_sync_strobe_gen (
        .clk        (clk),
        .rst        (rst),
        .sync_trig  (sync_trig),
        .vlock_n    (vlock_n),
        .edge_gate  (edge_gate),
        .tip_samp_n (tip_samp_n),
        .bp_samp_n  (bp_samp_n),
        .busy       (busy)
    );

    function automatic bit in_win(int c, int s);
        return (c >= s) && (c <= s + SLEN - 1);
    endfunction

    task automatic check(string tag, string name, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, name, act, exp, $time);
        end
    endtask

    // driver: one clock of stimulus, expected outputs pushed for after the edge
    task automatic step(input logic t, input logic lk, input logic r);
        logic  eg, et, eb, ez;
        string sg, st, sb, sz;
        @(negedge clk);
        sync_trig = t;
        vlock_n   = lk;
        rst       = r;
        if (r) begin
            eg = 1'b0; et = 1'b1; eb = 1'b1; ez = 1'b0;
            sg = "R1"; st = "R1"; sb = "R1"; sz = "R1";
            m_run = 1'b0;
            m_cnt = 0;
        end else begin
            eg = m_run && in_win(m_cnt, G0);
            et = !(m_run && in_win(m_cnt, T0) && lk);
            eb = !(m_run && in_win(m_cnt, B0) && lk);
            sg = !m_run ? "R2" : (!lk && in_win(m_cnt, G0)) ? "R7" : "R4";
            st = !m_run ? "R2" : (!lk && in_win(m_cnt, T0)) ? "R7" : "R5";
            sb = !m_run ? "R2" : (!lk && in_win(m_cnt, B0)) ? "R7" : "R6";
            if (!m_run)             sz = t ? "R3" : "R2";
            else if (m_cnt == TERM) sz = "R8";
            else if (t)             sz = "R9";
            else                    sz = "R3";
            if (!m_run) begin
                if (t) begin
                    m_run = 1'b1;
                    m_cnt = 0;
                end
            end else if (m_cnt == TERM) begin
                m_run = 1'b0;
                m_cnt = 0;
            end else begin
                m_cnt++;
            end
            ez = m_run;
        end
        exp_q.push_back({eg, et, eb, ez});
        tg_q.push_back(sg);
        tt_q.push_back(st);
        tb_q.push_back(sb);
        tz_q.push_back(sz);
    endtask

    // monitor: samples well after each edge, inputs change only at negedge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [3:0] e;
            string a, b, c, d;
            e = exp_q.pop_front();
            a = tg_q.pop_front();
            b = tt_q.pop_front();
            c = tb_q.pop_front();
            d = tz_q.pop_front();
            check(a, "edge_gate",  edge_gate,  e[3]);
            check(b, "tip_samp_n", tip_samp_n, e[2]);
            check(c, "bp_samp_n",  bp_samp_n,  e[1]);
            check(d, "busy",       busy,       e[0]);
        end
    end

    initial begin
        // R1: reset state
        repeat (3) step(1'b0, 1'b1, 1'b1);
        // R2: idle with lockout wiggling and no trigger
        for (int j = 0; j < 20; j++) step(1'b0, j[1], 1'b0);
        // R3 R4 R5 R6 R8: plain run, lockout released
        for (int j = 0; j < 530; j++) step(j == 0, 1'b1, 1'b0);
        // R7: whole run under lockout
        for (int j = 0; j < 530; j++) step(j == 0, 1'b0, 1'b0);
        // R7 R9: partial lockout, stray triggers mid-run and at the terminal edge
        for (int j = 0; j < 530; j++) begin
            logic lk;
            lk = !((j >= 16 && j <= 18) || j == 33 || j == 41 || j == 5);
            step(j == 0 || j == 3 || j == 200 || j == TERM + 1, lk, 1'b0);
        end
        // R8 R9: trigger held high, runs re-arm straight after each wrap
        for (int j = 0; j < 1100; j++) step(1'b1, 1'b1, 1'b0);
        // R1: reset in the middle of a run, then a fresh run
        for (int j = 0; j < 8; j++) step(1'b0, 1'b1, 1'b0);
        for (int j = 0; j < 30; j++) step(j == 0, 1'b1, 1'b0);
        repeat (2) step(1'b0, 1'b1, 1'b1);
        for (int j = 0; j < 60; j++) step(j == 5, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule